// File: doc/BRIEF.md
# Nonvolatile Word Array with Clear-Only Programming

This block models a small nonvolatile memory whose cells behave like NOR-type storage. Any word can be read at any time through a registered random-access port. Two commands modify the array, and both use a request/acknowledge handshake: a word program and a block erase. A program can only drive bits from one to zero, so the stored word becomes the old value ANDed with the new data. The only way to return bits to one is an erase, and an erase always sets every word of the addressed block to all ones.

Each accepted command holds the block busy for a number of cycles set by a parameter, and erase is much slower than program. While busy, the block refuses new commands and the read port keeps returning the contents as they were before the operation. The update lands in the array at the clock edge that ends the busy window. A program that asks for a zero-to-one transition still stores the AND of old and new data, and it also sets a sticky verify-error flag. Reset clears that flag and the control state, but it leaves the array contents as they are.

Word addresses are split into two fields. The low log2(WORDS_PER_BLOCK) bits select a word within a block, and the bits above them select the block. An erase looks only at the block field of its address.

Top module: `nvm_array_emu`

## Requirements
- R1: An erase sets every bit of every word in the addressed block to 1 and leaves every word in other blocks unchanged.
- R2: A program of data D to a word holding O leaves O AND D stored at that word, and no other word changes.
- R3: Successive programs to one word without an erase, where each value clears a subset of the remaining ones, produce each value in turn and never set the verify-error flag.
- R4: `vfy_err` goes high once a program's data has a 1 where the stored word has a 0. It then stays high until reset, and reset returns it to 0.
- R5: A request seen while not busy is acknowledged by a `cmd_ack` pulse one cycle long in the next cycle, and `busy` is high in that same cycle.
- R6: `busy` stays high for exactly PROG_CYCLES cycles after a program is accepted, and for exactly ERASE_CYCLES cycles after an erase is accepted.
- R7: A request made while `busy` is high gets no acknowledge and has no effect on the array.
- R8: `rd_data` shows the word at the `rd_addr` of the previous cycle. While `busy` is high it shows the contents as they were before the operation in progress.
- R9: Reset drives `busy`, `cmd_ack` and `vfy_err` low and does not alter the array contents.
- R10: An erase selects its block from address bits [ADDR_W-1:log2(WORDS_PER_BLOCK)] and ignores the word-offset bits below them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read data, one cycle after the address |
| cmd_req | input | 1 | Command request, held until acknowledged |
| cmd_erase | input | 1 | 1 = block erase, 0 = word program |
| cmd_addr | input | ADDR_W | Target word (program) or any word of the target block (erase) |
| cmd_wdata | input | DATA_W | Program data |
| cmd_ack | output | 1 | One-cycle acknowledge of an accepted command |
| busy | output | 1 | An operation is in progress |
| vfy_err | output | 1 | Sticky flag for a program that asked for a 0-to-1 transition |

## Verification
The hardest state to reach from the ports is a long erase in progress while a second request is pending and a read targets a word inside the block being erased. The bench starts an erase and, in the same cycle the acknowledge arrives, aims the read port at a word in that block. It holds a conflicting program request to another block through the early busy cycles and checks every busy cycle for a missing acknowledge and for the old data on the read port. Full read sweeps afterwards show that the erase reached exactly one block and that the refused program never landed.

// File: rtl/nvm_emu_pkg.sv
package nvm_emu_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } nvm_op_e;
endpackage

// File: rtl/nvm_rst_sync.sv
module nvm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
  import nvm_emu_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 3,
  parameter int ERASE_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_req,
  input  logic              cmd_erase,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [DATA_W-1:0] old_word,
  output logic              cmd_ack,
  output logic              busy,
  output logic              commit,
  output nvm_op_e           op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              vfy_err
);
  localparam int CNT_W = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES + 1) : 1;
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

  logic             busy_q, busy_d;
  logic             ack_q, ack_d;
  logic             vfy_q, vfy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;
  logic             bad_bits;

  assign accept   = cmd_req && !busy_q;
  assign commit   = busy_q && (cnt_q == '0);
  assign bad_bits = |(~old_word & data_q);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    ack_d  = 1'b0;
    vfy_d  = vfy_q;
    if (accept) begin
      busy_d = 1'b1;
      ack_d  = 1'b1;
      cnt_d  = cmd_erase ? ERASE_LOAD : PROG_LOAD;
    end else if (commit) begin
      busy_d = 1'b0;
      if (op_q == OP_PROG && bad_bits) begin
        vfy_d = 1'b1;
      end
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
      vfy_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ack_q  <= ack_d;
      vfy_q  <= vfy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      op_q   <= cmd_erase ? OP_ERASE : OP_PROG;
      addr_q <= cmd_addr;
      data_q <= cmd_wdata;
    end
  end

  assign cmd_ack = ack_q;
  assign busy    = busy_q;
  assign vfy_err = vfy_q;
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array
  import nvm_emu_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int WORDS_PER_BLOCK = 4,
  parameter int DATA_W          = 8,
  parameter int ADDR_W          = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              commit,
  input  nvm_op_e           op,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] old_word
);
  localparam int NUM_WORDS = NUM_BLOCKS * WORDS_PER_BLOCK;

  logic [NUM_WORDS-1:0][DATA_W-1:0] cells;
  logic [ADDR_W-1:0]                tgt_blk;
  logic [DATA_W-1:0]                rd_q;

  assign tgt_blk  = tgt_addr / ADDR_W'(WORDS_PER_BLOCK);
  assign old_word = cells[tgt_addr];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(w);
    localparam logic [ADDR_W-1:0] WORD_BLK  = ADDR_W'(w / WORDS_PER_BLOCK);
    logic              prog_hit;
    logic              erase_hit;
    logic              word_en;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_d;

    assign prog_hit  = commit && (op == OP_PROG)  && (tgt_addr == WORD_ADDR);
    assign erase_hit = commit && (op == OP_ERASE) && (tgt_blk == WORD_BLK);
    assign word_en   = prog_hit || erase_hit;

    always_comb begin
      if (erase_hit) word_d = '1;
      else           word_d = word_q & wdata;
    end

    always_ff @(posedge clk) begin
      if (word_en) word_q <= word_d;
    end

    assign cells[w] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= cells[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/nvm_array_emu.sv
module nvm_array_emu
  import nvm_emu_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int WORDS_PER_BLOCK = 4,
  parameter int DATA_W          = 8,
  parameter int PROG_CYCLES     = 3,
  parameter int ERASE_CYCLES    = 12,
  localparam int ADDR_W = $clog2(NUM_BLOCKS * WORDS_PER_BLOCK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cmd_req,
  input  logic              cmd_erase,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ack,
  output logic              busy,
  output logic              vfy_err
);
  logic              rst_n_int;
  logic              commit;
  nvm_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] old_word;

  nvm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  nvm_cmd_ctrl #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cmd_req   (cmd_req),
    .cmd_erase (cmd_erase),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .old_word  (old_word),
    .cmd_ack   (cmd_ack),
    .busy      (busy),
    .commit    (commit),
    .op_q      (op_q),
    .addr_q    (addr_q),
    .data_q    (data_q),
    .vfy_err   (vfy_err)
  );

  nvm_cell_array #(
    .NUM_BLOCKS      (NUM_BLOCKS),
    .WORDS_PER_BLOCK (WORDS_PER_BLOCK),
    .DATA_W          (DATA_W),
    .ADDR_W          (ADDR_W)
  ) u_cells (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .commit   (commit),
    .op       (op_q),
    .tgt_addr (addr_q),
    .wdata    (data_q),
    .old_word (old_word)
  );
endmodule

// File: rtl/nvm_array_emu_chk.sv
module nvm_array_emu_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_req,
  input logic              cmd_ack,
  input logic              busy,
  input logic              vfy_err,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  assert_ack_needs_idle_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> ($past(cmd_req) && !$past(busy)));

  assert_ack_with_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> busy);

  assert_ack_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |=> !cmd_ack);

  assert_busy_rise_acked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cmd_ack);

  assert_vfy_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_err |=> vfy_err);

  assert_read_frozen_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(rd_addr)) |=> $stable(rd_data));
endmodule

bind nvm_array_emu nvm_array_emu_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmd_req (cmd_req),
  .cmd_ack (cmd_ack),
  .busy    (busy),
  .vfy_err (vfy_err),
  .rd_addr (rd_addr),
  .rd_data (rd_data)
);

// File: tb/tb_nvm_array_emu.sv
module tb_nvm_array_emu;
  localparam int CLK_PERIOD = 10;
  localparam int NB    = 4;
  localparam int WPB   = 4;
  localparam int DW    = 8;
  localparam int PROGC = 3;
  localparam int ERSC  = 12;
  localparam int NW    = NB * WPB;
  localparam int AW    = $clog2(NW);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          cmd_req;
  logic          cmd_erase;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic          cmd_ack;
  logic          busy;
  logic          vfy_err;

  logic [DW-1:0] model [NW];
  logic          exp_vfy;
  int            checks = 0;
  int            fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_array_emu #(
    .NUM_BLOCKS      (NB),
    .WORDS_PER_BLOCK (WPB),
    .DATA_W          (DW),
    .PROG_CYCLES     (PROGC),
    .ERASE_CYCLES    (ERSC)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .cmd_req   (cmd_req),
    .cmd_erase (cmd_erase),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_ack   (cmd_ack),
    .busy      (busy),
    .vfy_err   (vfy_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd_check(input int a, input string req);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    chk(rd_data === model[a], req, 32'(rd_data), 32'(model[a]));
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < NW; i++) rd_check(i, req);
  endtask

  // Issue one command, check handshake and busy length, then update the model.
  task automatic do_cmd(input logic er, input int a, input logic [DW-1:0] d);
    int n;
    @(negedge clk);
    cmd_req = 1'b1; cmd_erase = er; cmd_addr = AW'(a); cmd_wdata = d;
    @(negedge clk);
    chk(cmd_ack === 1'b1 && busy === 1'b1, "R5 ack+busy", {30'd0, cmd_ack, busy}, 32'h3);
    cmd_req = 1'b0;
    n = 1;
    while (busy === 1'b1) begin
      @(negedge clk);
      if (busy === 1'b1) n++;
    end
    chk(n == (er ? ERSC : PROGC), "R6 busy length", 32'(n), 32'(er ? ERSC : PROGC));
    if (er) begin
      for (int i = 0; i < NW; i++) if (i / WPB == a / WPB) model[i] = '1;
    end else begin
      if (|(~model[a] & d)) exp_vfy = 1'b1;
      model[a] = model[a] & d;
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R9 busy in reset", 32'(busy), 32'h0);
    chk(cmd_ack === 1'b0, "R9 ack in reset", 32'(cmd_ack), 32'h0);
    chk(vfy_err === 1'b0, "R4 R9 vfy cleared by reset", 32'(vfy_err), 32'h0);
    rst_n = 1'b1;
    exp_vfy = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] chain [4];
    logic [DW-1:0] pre;
    rst_n = 1'b0; rd_addr = '0; cmd_req = 1'b0; cmd_erase = 1'b0;
    cmd_addr = '0; cmd_wdata = '0; exp_vfy = 1'b0;
    for (int i = 0; i < NW; i++) model[i] = 'x;
    repeat (2) @(negedge clk);
    apply_reset();

    // R1: erase every block, all words read back as ones
    for (int b = 0; b < NB; b++) do_cmd(1'b1, b * WPB + (b % WPB), '0);
    sweep("R1 erase all");

    // R3: clear-only chain on one word without erase
    chain[0] = 8'hFE; chain[1] = 8'hBA; chain[2] = 8'h32; chain[3] = 8'h00;
    for (int k = 0; k < 4; k++) begin
      do_cmd(1'b0, 5, chain[k]);
      rd_check(5, "R3 chain value");
      chk(vfy_err === 1'b0, "R3 no verify error", 32'(vfy_err), 32'h0);
    end

    // R10: erase addressed with a nonzero word offset restores block 1
    do_cmd(1'b1, 7, '0);
    sweep("R10 R1 offset ignored");

    // R2: program every word from the erased state
    for (int i = 0; i < NW; i++) do_cmd(1'b0, i, DW'(i * 37 + 5));
    sweep("R2 program from erased");
    chk(vfy_err === 1'b0, "R4 no error from erased", 32'(vfy_err), 32'h0);

    // R2 R4: reprogram every word, some asking for 0->1
    for (int i = 0; i < NW; i++) begin
      do_cmd(1'b0, i, DW'(i * 91 + 3));
      chk(vfy_err === exp_vfy, "R4 verify flag", 32'(vfy_err), 32'(exp_vfy));
    end
    sweep("R2 AND merge");

    // R7 R8: erase block 2, probe inside it, intrude on word 1
    pre = model[9];
    @(negedge clk);
    cmd_req = 1'b1; cmd_erase = 1'b1; cmd_addr = AW'(10); cmd_wdata = '0;
    @(negedge clk);
    chk(cmd_ack === 1'b1, "R5 erase ack", 32'(cmd_ack), 32'h1);
    rd_addr = AW'(9);
    cmd_erase = 1'b0; cmd_addr = AW'(1); cmd_wdata = 8'h00;
    for (int c = 1; c < ERSC; c++) begin
      if (c == 5) cmd_req = 1'b0;
      @(negedge clk);
      if (busy === 1'b1) begin
        chk(cmd_ack === 1'b0, "R7 refused while busy", 32'(cmd_ack), 32'h0);
        chk(rd_data === pre, "R8 old data during busy", 32'(rd_data), 32'(pre));
      end
    end
    cmd_req = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R6 erase done", 32'(busy), 32'h0);
    for (int i = 8; i < 12; i++) model[i] = '1;
    sweep("R7 R1 erase result");

    // R9: reset keeps contents, clears the flag
    apply_reset();
    sweep("R9 contents survive reset");
    do_cmd(1'b0, 0, 8'h00);
    chk(vfy_err === 1'b0, "R4 flag stays clear", 32'(vfy_err), 32'h0);
    rd_check(0, "R2 after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule